// File: doc/BRIEF.md
# Multi-Mode DMA Channel Priority Arbiter

This block decides which of four DMA channels is served next. Each channel raises a request line. A combinational picker grants the requesting channel that ranks highest in a stored priority order. The grant is a one-hot vector with a valid flag. The stored order is also driven out so that the surrounding controller, or a checker, can see it.

A two-bit policy field chooses how the order behaves:

- Two policies keep a fixed ranking.
- One policy rotates all four channels.
- One policy rotates only the channels marked in a four-bit membership mask.

When a transfer ends, the controller pulses a strobe together with the number of the channel that finished. In the rotating policies, that channel is moved to the last rank among the rotating channels. Changing the configuration discards the rotation history and restores the starting order of the newly selected policy.

Top module: `dma_prio_arbiter`

## Requirements
- R1: A synchronous active-high reset sets the order to channel 0 > 1 > 2 > 3 and clears the stored configuration to policy 00 with mask 0000.
- R2: With policy 00, the order is fixed at 0 > 1 > 2 > 3, and transfer-end strobes leave it unchanged.
- R3: With policy 01, the order is fixed at 0 > 2 > 3 > 1, and transfer-end strobes leave it unchanged.
- R4: With policy 11, a transfer end on channel c moves c to the lowest rank from the next cycle on. The other three channels keep their relative order.
- R5: With policy 10, a transfer end on channel c, where mask bit c is 1, moves c to the last of the ranks held by mask members. The other members keep their relative order, and non-members keep their ranks.
- R6: With policy 10, a transfer end on a channel whose mask bit is 0 leaves the order unchanged.
- R7: Under policies 00, 01 and 11 the mask has no effect: changing it neither reinitialises nor alters the order or the grant.
- R8: A change of the policy field, or a change of the mask while policy 10 is selected, sets the order on the next edge to the starting order of the new policy. That is 0 > 2 > 3 > 1 for policy 01 and 0 > 1 > 2 > 3 otherwise. A transfer-end strobe in the same cycle is ignored.
- R9: The grant is combinational. It is one-hot, names the requesting channel with the best rank in the current order, and is all-zero with valid low when no request is active.
- R10: The order output carries rank i (rank 0 is highest) in bits [2i+1:2i] as a binary channel number. It always holds a permutation of the four channels and changes only at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 4 | Request line per channel, bit n for channel n |
| mode_i | input | 2 | Policy: 00 fixed linear, 01 fixed alternate, 10 subset rotation, 11 full rotation |
| rr_sel_i | input | 4 | Rotation membership mask for policy 10, bit n for channel n |
| xfer_done_i | input | 1 | Transfer-end strobe, one cycle per finished transfer |
| xfer_done_ch_i | input | 2 | Binary number of the channel whose transfer ended |
| grant_o | output | 4 | One-hot grant, bit n for channel n |
| grant_valid_o | output | 1 | High when any request is active |
| order_o | output | 8 | Current ranking, rank i in bits [2i+1:2i] |

## Verification
The two functions that can fall in the same cycle are a configuration change (new policy, or a new mask under policy 10) and a transfer-end strobe. The bench drives both in one cycle, in several policies. It then checks that the next order equals the fresh starting order with no rotation applied. A second collision is a mask change under policy 11 together with a strobe. There the rotation must still happen. A long stretch of random stimulus runs against a reference model built from the requirements.

// File: rtl/dma_prio_pkg.sv
package dma_prio_pkg;

    localparam int NCH = 4;
    localparam int CW  = $clog2(NCH);

    typedef logic [CW-1:0]  ch_t;
    typedef ch_t  [NCH-1:0] ord_t;   // index 0 = highest rank
    typedef logic [NCH-1:0] vec_t;

    typedef enum logic [1:0] {
        PM_FIXED_LIN = 2'b00,
        PM_FIXED_ALT = 2'b01,
        PM_RR_SUBSET = 2'b10,
        PM_RR_ALL    = 2'b11
    } pmode_t;

    // Starting order for a policy
    function automatic ord_t init_order(pmode_t m);
        ord_t r;
        for (int i = 0; i < NCH; i++) r[i] = ch_t'(i);
        if (m == PM_FIXED_ALT) begin
            r[0] = ch_t'(0);
            for (int i = 1; i < NCH - 1; i++) r[i] = ch_t'(i + 1);
            r[NCH-1] = ch_t'(1);
        end
        return r;
    endfunction

    // Move channel c behind all other members, inside the member slots only
    function automatic ord_t rotate(ord_t o, vec_t mem, ch_t c);
        ord_t r;
        ord_t seq;
        int   k;
        r   = o;
        seq = o;
        k   = 0;
        if (mem[c]) begin
            for (int i = 0; i < NCH; i++) begin
                if (mem[o[i]] && (o[i] != c)) begin
                    seq[k] = o[i];
                    k++;
                end
            end
            seq[k] = c;
            k = 0;
            for (int i = 0; i < NCH; i++) begin
                if (mem[o[i]]) begin
                    r[i] = seq[k];
                    k++;
                end
            end
        end
        return r;
    endfunction

    // Best-ranked requester; scan from lowest rank so the highest wins last
    function automatic vec_t pick(ord_t o, vec_t req);
        vec_t g;
        g = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[o[i]]) begin
                g = '0;
                g[o[i]] = 1'b1;
            end
        end
        return g;
    endfunction

    function automatic logic is_perm(ord_t o);
        vec_t seen;
        seen = '0;
        for (int i = 0; i < NCH; i++) seen[o[i]] = 1'b1;
        return &seen;
    endfunction

endpackage

// File: rtl/dma_prio_order.sv
module dma_prio_order
    import dma_prio_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  pmode_t mode,
    input  vec_t   rr_sel,
    input  logic   done,
    input  ch_t    done_ch,
    output ord_t   order
);

    ord_t   order_q;
    pmode_t mode_q;
    vec_t   sel_q;
    logic   reinit;
    vec_t   members;
    ord_t   order_d;

    assign reinit = (mode != mode_q) ||
                    ((mode == PM_RR_SUBSET) && (rr_sel != sel_q));

    always_comb begin
        unique case (mode)
            PM_RR_ALL:    members = '1;
            PM_RR_SUBSET: members = rr_sel;
            default:      members = '0;
        endcase
    end

    always_comb begin
        if (reinit)
            order_d = init_order(mode);
        else if (done && (members != '0))
            order_d = rotate(order_q, members, done_ch);
        else
            order_d = order_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            order_q <= init_order(PM_FIXED_LIN);
            mode_q  <= PM_FIXED_LIN;
            sel_q   <= '0;
        end else begin
            order_q <= order_d;
            mode_q  <= mode;
            sel_q   <= rr_sel;
        end
    end

    assign order = order_q;

    // R1
    a_r1_reset_order: assert property (@(posedge clk)
        rst |=> (order_q == init_order(PM_FIXED_LIN)));

    // R2 / R3
    a_r2_fixed_hold: assert property (@(posedge clk) disable iff (rst)
        (!reinit && ((mode == PM_FIXED_LIN) || (mode == PM_FIXED_ALT)))
        |=> $stable(order_q));

    // R4
    a_r4_rr_tail: assert property (@(posedge clk) disable iff (rst)
        (!reinit && done && (mode == PM_RR_ALL))
        |=> (order_q[NCH-1] == $past(done_ch)));

    // R6
    a_r6_nonmember_hold: assert property (@(posedge clk) disable iff (rst)
        (!reinit && done && (mode == PM_RR_SUBSET) && !rr_sel[done_ch])
        |=> $stable(order_q));

    // R8
    a_r8_reinit_start: assert property (@(posedge clk) disable iff (rst)
        (reinit && (mode == PM_FIXED_ALT))
        |=> (order_q[NCH-1] == ch_t'(1)));

    // R10
    a_r10_permutation: assert property (@(posedge clk) disable iff (rst)
        is_perm(order_q));

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick
    import dma_prio_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ord_t order,
    input  vec_t req,
    output vec_t grant,
    output logic valid
);

    assign grant = pick(order, req);
    assign valid = |req;

    // R9
    a_r9_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    a_r9_granted_requested: assert property (@(posedge clk) disable iff (rst)
        ((grant & ~req) == '0));

    a_r9_valid_matches: assert property (@(posedge clk) disable iff (rst)
        (valid == (grant != '0)));

    a_r9_top_rank_wins: assert property (@(posedge clk) disable iff (rst)
        req[order[0]] |-> grant[order[0]]);

endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
    import dma_prio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] req_i,
    input  logic [1:0] mode_i,
    input  logic [3:0] rr_sel_i,
    input  logic       xfer_done_i,
    input  logic [1:0] xfer_done_ch_i,
    output logic [3:0] grant_o,
    output logic       grant_valid_o,
    output logic [7:0] order_o
);

    ord_t order;

    dma_prio_order u_order (
        .clk     (clk),
        .rst     (rst),
        .mode    (pmode_t'(mode_i)),
        .rr_sel  (rr_sel_i),
        .done    (xfer_done_i),
        .done_ch (xfer_done_ch_i),
        .order   (order)
    );

    dma_prio_pick u_pick (
        .clk   (clk),
        .rst   (rst),
        .order (order),
        .req   (req_i),
        .grant (grant_o),
        .valid (grant_valid_o)
    );

    assign order_o = order;

endmodule

// File: tb/sim_dma_prio_arbiter.sv
`timescale 1ns/1ps
module sim_dma_prio_arbiter;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] req;
    logic [1:0] mode;
    logic [3:0] sel;
    logic       dn;
    logic [1:0] dch;
    logic [3:0] grant;
    logic       gvalid;
    logic [7:0] order;

    always #2 clk = ~clk;   // 250 MHz

    dma_prio_arbiter u0 (
        .clk(clk), .rst(rst), .req_i(req), .mode_i(mode), .rr_sel_i(sel),
        .xfer_done_i(dn), .xfer_done_ch_i(dch),
        .grant_o(grant), .grant_valid_o(gvalid), .order_o(order)
    );

    typedef struct {
        logic [7:0] ord;
        logic [3:0] gnt;
        logic       vld;
        string      tag;
    } exp_t;

    exp_t exq[$];
    int   checks = 0;
    int   fails  = 0;
    bit   finished = 0;

    int         m_ord[4];
    int         m_mode;
    logic [3:0] m_sel;

    function automatic void m_init(int md);
        if (md == 1) begin m_ord[0]=0; m_ord[1]=2; m_ord[2]=3; m_ord[3]=1; end
        else         begin m_ord[0]=0; m_ord[1]=1; m_ord[2]=2; m_ord[3]=3; end
    endfunction

    function automatic void m_rotate(logic [3:0] mem, int c);
        int lst[$];
        if (!mem[c]) return;
        foreach (m_ord[i]) if (mem[m_ord[i]] && m_ord[i] != c) lst.push_back(m_ord[i]);
        lst.push_back(c);
        foreach (m_ord[i]) if (mem[m_ord[i]]) m_ord[i] = lst.pop_front();
    endfunction

    task automatic step(input logic [3:0] rq, input logic [1:0] md, input logic [3:0] sl,
                        input logic d, input logic [1:0] c, input string tag);
        exp_t e;
        bit   ri;
        logic [3:0] mem;
        @(negedge clk);
        req = rq; mode = md; sel = sl; dn = d; dch = c;
        for (int i = 0; i < 4; i++) e.ord[2*i +: 2] = 2'(m_ord[i]);
        e.gnt = 4'b0;
        for (int i = 3; i >= 0; i--) if (rq[m_ord[i]]) begin e.gnt = 4'b0; e.gnt[m_ord[i]] = 1'b1; end
        e.vld = |rq;
        e.tag = tag;
        exq.push_back(e);
        ri = (int'(md) != m_mode) || (md == 2'b10 && sl != m_sel);
        mem = (md == 2'b11) ? 4'hF : (md == 2'b10) ? sl : 4'h0;
        if (ri) m_init(int'(md));
        else if (d) m_rotate(mem, int'(c));
        m_mode = int'(md);
        m_sel  = sl;
    endtask

    // monitor
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (exq.size() > 0) begin
                e = exq.pop_front();
                checks++;
                if (order !== e.ord || grant !== e.gnt || gvalid !== e.vld) begin
                    fails++;
                    $display("FAIL %s: order=%h grant=%b valid=%b expected order=%h grant=%b valid=%b",
                             e.tag, order, grant, gvalid, e.ord, e.gnt, e.vld);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req = '0; mode = '0; sel = '0; dn = 1'b0; dch = '0;
        m_init(0); m_mode = 0; m_sel = 4'h0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        step(4'b1111, 2'b00, 4'h0, 0, 2'd0, "R1 reset order");
        step(4'b0000, 2'b00, 4'h0, 0, 2'd0, "R9 no request");
        step(4'b0110, 2'b00, 4'h0, 1, 2'd1, "R2 done in fixed");
        step(4'b0110, 2'b00, 4'h0, 0, 2'd0, "R2 order held");
        step(4'b1100, 2'b00, 4'hA, 1, 2'd2, "R7 mask in 00");
        step(4'b1100, 2'b00, 4'h5, 0, 2'd0, "R7 no reinit 00");
        step(4'b1010, 2'b01, 4'h5, 0, 2'd0, "R8 mode change");
        step(4'b1010, 2'b01, 4'h5, 1, 2'd0, "R3 alt order");
        step(4'b1010, 2'b01, 4'h5, 0, 2'd0, "R3 done ignored");
        step(4'b0010, 2'b11, 4'h5, 0, 2'd0, "R8 into full rr");
        step(4'b0110, 2'b11, 4'h5, 1, 2'd1, "R4 restart order");
        step(4'b0110, 2'b11, 4'h5, 1, 2'd2, "R4 ch1 to tail");
        step(4'b0110, 2'b11, 4'h3, 1, 2'd0, "R4 ch2 to tail");
        step(4'b1111, 2'b11, 4'h3, 0, 2'd0, "R7 mask in 11");
        step(4'b1111, 2'b10, 4'hE, 0, 2'd0, "R8 into subset");
        step(4'b1110, 2'b10, 4'hE, 1, 2'd1, "R5 restart order");
        step(4'b1110, 2'b10, 4'hE, 1, 2'd3, "R5 ch1 rotates");
        step(4'b1111, 2'b10, 4'hE, 1, 2'd0, "R5 ch3 rotates");
        step(4'b1111, 2'b10, 4'hE, 0, 2'd0, "R6 nonmember held");
        step(4'b1111, 2'b10, 4'h5, 0, 2'd0, "R8 mask change");
        step(4'b1111, 2'b10, 4'h5, 1, 2'd0, "R8 restarted");
        step(4'b1110, 2'b10, 4'h5, 0, 2'd0, "R5 ch0 member slots");
        step(4'b0101, 2'b10, 4'h6, 1, 2'd2, "R8 collision mask+done");
        step(4'b0101, 2'b11, 4'h6, 1, 2'd0, "R8 collision mode+done");
        step(4'b0101, 2'b11, 4'h6, 0, 2'd0, "R8 no rotation applied");

        for (int n = 0; n < 400; n++) begin
            logic [1:0] md;
            logic [3:0] sl;
            md = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(0, 3)) : mode;
            sl = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 15)) : sel;
            step(4'($urandom_range(0, 15)), md, sl, 1'($urandom_range(0, 1)),
                 2'($urandom_range(0, 3)), "R10 random stream");
        end

        @(negedge clk);
        @(negedge clk);
        #2;
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule